// File: doc/BRIEF.md
# Slot Task Activation Controller

Each reconfigurable slot of a control fabric carries one copy of this controller. It tracks the slot's life cycle through three states: empty (no task configured), armed (task configured but idle) and running (task drives its outputs). The controllers of one module share a broadcast bus that carries 8-bit task identifiers. An armed controller whose fixed identifier appears on the bus takes over. A running controller whose exit condition fires passes control on: it broadcasts its successor's identifier, asks for the successor's configuration to be loaded, and goes back to armed.

No central sequencer exists. Each controller holds one state of the module's task sequence together with that state's outgoing transition, so the sequence is spread across the slots. Wiring several controllers with identifiers that form a ring gives a self-running hand-over chain. In that chain exactly one task is running at any time. During each hand-over there is a single cycle in which no task is running.

Top module: `task_slot_ctrl`

## Requirements
- R1: After reset the controller is empty, and out_en_o, proc_start_o, mark_send_o and load_req_o are 0 and mark_out_o is 0.
- R2: A high load_done_i in the empty state moves the controller to armed at the next clock edge.
- R3: In armed, a cycle with mark_vld_i high and mark_i equal to OWN_ID moves the controller to running at the next edge. out_en_o is then high from that edge on, and proc_start_o is high for exactly the first running cycle.
- R4: In running, a high exit_cond_i returns the controller to armed at the next edge. In the cycle after that edge, out_en_o is 0, mark_send_o and load_req_o are 1, and mark_out_o equals NEXT_ID.
- R5: mark_send_o and load_req_o are one-cycle pulses. mark_out_o is 0 whenever mark_send_o is 0, so several controllers can share a bus by OR-ing their outputs.
- R6: A high replaced_i in armed returns the controller to empty at the next edge. It takes priority over a matching marker in the same cycle. After that, a matching marker no longer activates the controller until load_done_i is seen again.
- R7: A marker whose value differs from OWN_ID has no effect. A marker of any value that arrives in the empty or running state has no effect, and a running task does not restart.
- R8: exit_cond_i has no effect outside the running state.
- R9: In a ring of controllers, at most one has out_en_o high at any time. Each hand-over leaves exactly one cycle with none high, followed by the successor's proc_start_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_done_i | input | 1 | Slot configuration finished |
| replaced_i | input | 1 | Slot configuration is being overwritten |
| mark_vld_i | input | 1 | Bus marker valid strobe |
| mark_i | input | 8 | Bus marker value |
| exit_cond_i | input | 1 | Task exit condition, sampled each clock |
| out_en_o | output | 1 | Task output enable (high while running) |
| proc_start_o | output | 1 | One-cycle pulse at start of signal processing |
| mark_send_o | output | 1 | One-cycle marker broadcast strobe |
| mark_out_o | output | 8 | Broadcast marker value (NEXT_ID while sending, else 0) |
| load_req_o | output | 1 | One-cycle request to load the next task |

## Verification
The assertions assume that mark_i is meaningful whenever mark_vld_i is high. They also assume that within a module no two controllers share an identifier. Finally, they assume the environment raises replaced_i only for a slot that is not running. The bench keeps to this. Markers are driven only as single-cycle strobes from the bus model. Every slot has a distinct ring identifier. replaced_i is raised only on a slot that is known to be armed, and exit conditions are raised only for one cycle.

// File: rtl/slot_ctrl_pkg.sv
package slot_ctrl_pkg;
  localparam int unsigned SLOT_ID_W = 8;
  typedef logic [SLOT_ID_W-1:0] slot_id_t;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_READY = 2'd1,
    ST_RUN   = 2'd2
  } slot_state_e;

  function automatic logic id_hit(input logic vld, input slot_id_t rx, input slot_id_t own);
    return vld && (rx == own);
  endfunction

  function automatic slot_id_t bus_value(input logic send, input slot_id_t id);
    return send ? id : '0;
  endfunction
endpackage

// File: rtl/slot_marker_cmp.sv
module slot_marker_cmp
  import slot_ctrl_pkg::*;
#(
  parameter slot_id_t OWN_ID = 8'h01
) (
  input  logic     mark_vld_i,
  input  slot_id_t mark_i,
  output logic     hit_o
);
  assign hit_o = id_hit(mark_vld_i, mark_i, OWN_ID);
endmodule

// File: rtl/slot_state_reg.sv
module slot_state_reg
  import slot_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_done_i,
  input  logic        replaced_i,
  input  logic        hit_i,
  input  logic        exit_cond_i,
  output slot_state_e state_o,
  output logic        enter_run_o,
  output logic        leave_run_o
);
  slot_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    enter_run_o = 1'b0;
    leave_run_o = 1'b0;
    unique case (state_q)
      ST_EMPTY: if (load_done_i) state_d = ST_READY;
      ST_READY: begin
        if (replaced_i) begin
          state_d = ST_EMPTY;
        end else if (hit_i) begin
          state_d     = ST_RUN;
          enter_run_o = 1'b1;
        end
      end
      ST_RUN: if (exit_cond_i) begin
        state_d     = ST_READY;
        leave_run_o = 1'b1;
      end
      default: state_d = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_EMPTY;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/slot_handoff_out.sv
module slot_handoff_out
  import slot_ctrl_pkg::*;
#(
  parameter slot_id_t NEXT_ID = 8'h02
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enter_run_i,
  input  logic     leave_run_i,
  output logic     proc_start_o,
  output logic     mark_send_o,
  output slot_id_t mark_out_o,
  output logic     load_req_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proc_start_o <= 1'b0;
      mark_send_o  <= 1'b0;
      mark_out_o   <= '0;
      load_req_o   <= 1'b0;
    end else begin
      proc_start_o <= enter_run_i;
      mark_send_o  <= leave_run_i;
      mark_out_o   <= bus_value(leave_run_i, NEXT_ID);
      load_req_o   <= leave_run_i;
    end
  end
endmodule

// File: rtl/task_slot_ctrl.sv
module task_slot_ctrl
  import slot_ctrl_pkg::*;
#(
  parameter slot_id_t OWN_ID  = 8'h01,
  parameter slot_id_t NEXT_ID = 8'h02
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_done_i,
  input  logic                 replaced_i,
  input  logic                 mark_vld_i,
  input  logic [SLOT_ID_W-1:0] mark_i,
  input  logic                 exit_cond_i,
  output logic                 out_en_o,
  output logic                 proc_start_o,
  output logic                 mark_send_o,
  output logic [SLOT_ID_W-1:0] mark_out_o,
  output logic                 load_req_o
);
  logic        hit_w;
  logic        enter_run_w;
  logic        leave_run_w;
  slot_state_e state_w;

  slot_marker_cmp #(.OWN_ID(OWN_ID)) u_cmp (
    .mark_vld_i (mark_vld_i),
    .mark_i     (mark_i),
    .hit_o      (hit_w)
  );

  slot_state_reg u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_done_i (load_done_i),
    .replaced_i  (replaced_i),
    .hit_i       (hit_w),
    .exit_cond_i (exit_cond_i),
    .state_o     (state_w),
    .enter_run_o (enter_run_w),
    .leave_run_o (leave_run_w)
  );

  slot_handoff_out #(.NEXT_ID(NEXT_ID)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_run_i  (enter_run_w),
    .leave_run_i  (leave_run_w),
    .proc_start_o (proc_start_o),
    .mark_send_o  (mark_send_o),
    .mark_out_o   (mark_out_o),
    .load_req_o   (load_req_o)
  );

  // Enable decoded from the state register: it falls at the very edge that leaves running.
  assign out_en_o = (state_w == ST_RUN);
endmodule

// File: rtl/task_slot_ctrl_checker.sv
module task_slot_ctrl_checker
  import slot_ctrl_pkg::*;
#(
  parameter slot_id_t OWN_ID  = 8'h01,
  parameter slot_id_t NEXT_ID = 8'h02
) (
  input logic        clk,
  input logic        rst_n,
  input logic        replaced_i,
  input logic        exit_cond_i,
  input logic        hit_w,
  input slot_state_e state_w,
  input logic        out_en_o,
  input logic        proc_start_o,
  input logic        mark_send_o,
  input slot_id_t    mark_out_o,
  input logic        load_req_o
);
  AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_o) |-> ($past(hit_w) && $past(state_w) == ST_READY)); // R3
  AST_START_WHILE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    proc_start_o |-> (out_en_o && $rose(out_en_o))); // R3
  AST_SEND_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mark_send_o |-> (!out_en_o && $past(out_en_o))); // R4
  AST_SEND_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    mark_send_o |-> (mark_out_o == NEXT_ID && load_req_o)); // R4
  AST_SEND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mark_send_o |=> (!mark_send_o && !load_req_o)); // R5
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_send_o |-> (mark_out_o == '0)); // R5
  AST_REPLACE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_READY && replaced_i) |=> (state_w == ST_EMPTY && !out_en_o)); // R6
  AST_EMPTY_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_EMPTY) |=> !out_en_o); // R7
  AST_EXIT_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mark_send_o) |-> ($past(state_w) == ST_RUN && $past(exit_cond_i))); // R8
endmodule

bind task_slot_ctrl task_slot_ctrl_checker #(.OWN_ID(OWN_ID), .NEXT_ID(NEXT_ID)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .replaced_i   (replaced_i),
  .exit_cond_i  (exit_cond_i),
  .hit_w        (hit_w),
  .state_w      (state_w),
  .out_en_o     (out_en_o),
  .proc_start_o (proc_start_o),
  .mark_send_o  (mark_send_o),
  .mark_out_o   (mark_out_o),
  .load_req_o   (load_req_o)
);

// File: tb/task_slot_ctrl_bench.sv
module task_slot_ctrl_bench;
  localparam int N = 3;
  localparam logic [7:0] BASE = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] load_done, replaced, exit_c, out_en, pstart, send, lreq;
  logic [7:0]   mout [N];
  logic         tb_vld;
  logic [7:0]   tb_mark;
  logic         bus_vld;
  logic [7:0]   bus_mark;

  assign bus_vld  = tb_vld | (|send);
  assign bus_mark = tb_mark | mout[0] | mout[1] | mout[2];

  for (genvar g = 0; g < N; g++) begin : g_slot
    task_slot_ctrl #(
      .OWN_ID (BASE + 8'(g)),
      .NEXT_ID(BASE + 8'((g + 1) % N))
    ) u_task_slot_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_done_i  (load_done[g]),
      .replaced_i   (replaced[g]),
      .mark_vld_i   (bus_vld),
      .mark_i       (bus_mark),
      .exit_cond_i  (exit_c[g]),
      .out_en_o     (out_en[g]),
      .proc_start_o (pstart[g]),
      .mark_send_o  (send[g]),
      .mark_out_o   (mout[g]),
      .load_req_o   (lreq[g])
    );
  end

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R9: continuous watch, at most one running slot
  always @(negedge clk) begin
    if (rst_n && $countones(out_en) > 1) begin
      bad++;
      $display("FAIL R9 concurrent enables actual=%b expected=onehot0", out_en);
    end
  end

  // drive for one edge, then sample 1 ns after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_in();
    @(negedge clk);
    load_done = '0; replaced = '0; exit_c = '0; tb_vld = 1'b0; tb_mark = '0;
  endtask

  task automatic inject(input logic [7:0] m);
    @(negedge clk);
    tb_vld = 1'b1; tb_mark = m;
    step();
    clear_in();
  endtask

  task automatic t_reset();
    chk("R1", "out_en", int'(out_en), 0);
    chk("R1", "proc_start", int'(pstart), 0);
    chk("R1", "send", int'(send), 0);
    chk("R1", "load_req", int'(lreq), 0);
    chk("R1", "mark_out0", int'(mout[0]), 0);
  endtask

  task automatic t_empty_ignores();
    inject(BASE);
    chk("R7", "empty slot ignores own marker", int'(out_en), 0);
    @(negedge clk); exit_c = 3'b111;
    step(); clear_in();
    step();
    chk("R8", "exit while empty no send", int'(send), 0);
    chk("R8", "exit while empty no req", int'(lreq), 0);
  endtask

  task automatic t_load_and_mismatch();
    @(negedge clk); load_done = 3'b111;
    step(); clear_in();
    inject(8'h55);
    chk("R7", "mismatch marker ignored", int'(out_en), 0);
    @(negedge clk); exit_c = 3'b001;
    step(); clear_in();
    step();
    chk("R8", "exit while armed no send", int'(send), 0);
  endtask

  task automatic t_activate();
    inject(BASE);
    chk("R2", "armed after load, slot0 runs", int'(out_en), 1);
    chk("R3", "proc_start first cycle", int'(pstart), 1);
    step();
    chk("R3", "proc_start one cycle", int'(pstart), 0);
    chk("R3", "out_en held", int'(out_en), 1);
    inject(BASE);
    chk("R7", "running ignores own marker (no restart)", int'(pstart), 0);
    chk("R7", "running stays enabled", int'(out_en), 1);
  endtask

  task automatic handover(input int from, input int to);
    @(negedge clk); exit_c[from] = 1'b1;
    step(); clear_in();
    chk("R4", "out_en dropped", int'(out_en), 0);
    chk("R4", "send pulse", int'(send[from]), 1);
    chk("R4", "load_req pulse", int'(lreq[from]), 1);
    chk("R4", "marker value", int'(mout[from]), int'(BASE + 8'(to)));
    step();
    chk("R5", "send single cycle", int'(send[from]), 0);
    chk("R5", "load_req single cycle", int'(lreq[from]), 0);
    chk("R5", "idle bus zero", int'(mout[from]), 0);
    chk("R9", "successor running", int'(out_en), 1 << to);
    chk("R9", "successor start", int'(pstart), 1 << to);
  endtask

  task automatic t_ring();
    handover(0, 1);
    handover(1, 2);
    handover(2, 0);
    handover(0, 1);
  endtask

  task automatic t_replace();
    @(negedge clk); replaced[2] = 1'b1; tb_vld = 1'b1; tb_mark = BASE + 8'd2;
    step(); clear_in();
    chk("R6", "replace beats match", int'(out_en), 2);
    inject(BASE + 8'd2);
    chk("R6", "emptied slot ignores marker", int'(out_en), 2);
    @(negedge clk); exit_c[1] = 1'b1;
    step(); clear_in();
    chk("R4", "send toward empty slot", int'(send[1]), 1);
    step();
    chk("R6", "no slot runs after send to empty", int'(out_en), 0);
    @(negedge clk); load_done[2] = 1'b1;
    step(); clear_in();
    inject(BASE + 8'd2);
    chk("R2", "reloaded slot activates", int'(out_en), 4);
  endtask

  initial begin
    load_done = '0; replaced = '0; exit_c = '0; tb_vld = 1'b0; tb_mark = '0;
    repeat (3) step();
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_empty_ignores();
    t_load_and_mismatch();
    t_activate();
    t_ring();
    t_replace();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule